// File: doc/BRIEF.md
# Group Register Rename Unit

This block renames a group of up to four instructions in one clock cycle. Each instruction slot presents two logical source registers and an optional logical destination. An alias table turns each logical source into the physical register that currently holds its value. A circular free pool hands out an unused physical register for every destination in the group. Comparators inside the group detect a source that names the destination of an earlier slot in the same group. That source then takes the physical register just allocated to the earlier slot, because the table entry is stale for it.

All rename results are combinational on the same cycle as the request. The alias table and the free pool change at the following clock edge, and only if the group is accepted. When the pool cannot cover every destination in the group, the whole group is held back and nothing changes. A single release port returns one physical register per cycle to the pool. For each destination the block also reports the mapping that the destination displaced, so that a later stage can free that register when the instruction retires.

Top module: `group_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i, and the pool holds the physical registers LOG_REGS up to PHYS_REGS-1, which are handed out in ascending order.
- R2: Every allocating slot of an accepted group receives a distinct physical register. The registers are taken from the pool in slot order: the lowest-numbered allocating slot gets the oldest pool entry.
- R3: A source with no earlier allocating slot in the group that writes the same logical register reads its physical register from the alias table.
- R4: A source whose logical register is written by an earlier allocating slot in the group takes that slot's new physical register. If several earlier slots write it, the nearest earlier slot wins.
- R5: After an accepted group, the table holds the new mapping for every logical register written in the group. When several slots write the same register, the highest-numbered slot's mapping is kept.
- R6: The displaced-mapping output of an allocating slot gives the mapping that held just before that slot. For a register written earlier in the same group, this is the earlier slot's new register.
- R7: Logical register 0 always reads as physical register 0. A slot whose destination is register 0 allocates nothing and reports 0 as both its new and its displaced register.
- R8: A group that needs more registers than the pool holds raises out_stall and leaves out_fire low. The table and the pool are left unchanged. The group needs one register for each valid slot with a nonzero destination and the destination flag set.
- R9: A slot with its valid bit low, or with its destination flag low, allocates nothing and reports 0 for its new and displaced registers. A slot with its valid bit low also reports 0 on both source outputs and is never a bypass source for later slots.
- R10: A register released through the release port joins the tail of the pool at the clock edge. It can be allocated from the next cycle on, after every register already in the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A rename group is presented this cycle |
| in_slot_vld | input | GROUP_N | Per-slot instruction present |
| in_has_dst | input | GROUP_N | Per-slot destination flag |
| in_lsrc_a | input | GROUP_N x LW | First logical source per slot |
| in_lsrc_b | input | GROUP_N x LW | Second logical source per slot |
| in_ldst | input | GROUP_N x LW | Logical destination per slot |
| rel_valid | input | 1 | Release a physical register this cycle |
| rel_preg | input | PW | Physical register being released |
| out_fire | output | 1 | Group accepted; state updates at this edge |
| out_stall | output | 1 | Group held back for lack of free registers |
| out_psrc_a | output | GROUP_N x PW | Physical register for the first source |
| out_psrc_b | output | GROUP_N x PW | Physical register for the second source |
| out_pdst | output | GROUP_N x PW | Newly allocated physical destination |
| out_pold | output | GROUP_N x PW | Mapping displaced by the destination |

## Verification
A corrupted alias-table entry does not show when the group is renamed. It shows later, at the first source that reads that logical register without an in-group writer ahead of it. For this reason the bench re-reads every written register in a later group. A pool pointer or count that slips shows up at once in the allocated register numbers, or in a stall that comes one group too early or too late. The bench therefore drains the pool to exactly zero and then refills it through the release port. A wrong bypass priority only shows on sources that more than one earlier slot writes, so groups with repeated destinations are included.

// File: rtl/rename_pkg.sv
package rename_pkg;

   // Number of set bits of v strictly below position k.
   function automatic int unsigned ones_below(input logic [31:0] v, input int unsigned k);
      int unsigned n;
      n = 0;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i < k && v[i]) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
   parameter int LOG_REGS = 32,
   parameter int PHYS_REGS = 64,
   parameter int RD_PORTS = 12,
   parameter int WR_PORTS = 4,
   parameter int LW = $clog2(LOG_REGS),
   parameter int PW = $clog2(PHYS_REGS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [RD_PORTS-1:0][LW-1:0]       rd_idx,
   output logic [RD_PORTS-1:0][PW-1:0]       rd_map,
   input  logic [WR_PORTS-1:0]               wr_en,
   input  logic [WR_PORTS-1:0][LW-1:0]       wr_idx,
   input  logic [WR_PORTS-1:0][PW-1:0]       wr_map
);

   logic [PW-1:0] map_q [LOG_REGS];

   // Ports are applied in ascending order, so the highest slot wins.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LOG_REGS; i++) map_q[i] <= PW'(i);
      end else begin
         for (int w = 0; w < WR_PORTS; w++) begin
            if (wr_en[w]) map_q[wr_idx[w]] <= wr_map[w];
         end
      end
   end

   for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
      assign rd_map[r] = map_q[rd_idx[r]];
   end

endmodule

// File: rtl/rename_dep_check.sv
module rename_dep_check #(
   parameter int GROUP_N = 4,
   parameter int SLOT = 0,
   parameter int LW = 5,
   parameter int PW = 6
) (
   input  logic [LW-1:0]                lreg,
   input  logic [PW-1:0]                table_map,
   input  logic [GROUP_N-1:0][LW-1:0]   grp_ldst,
   input  logic [GROUP_N-1:0]           grp_alloc,
   input  logic [GROUP_N-1:0][PW-1:0]   grp_new,
   output logic [PW-1:0]                out_map
);

   // Scan older slots in order; a later match overrides, so the nearest writer wins.
   always_comb begin
      out_map = table_map;
      for (int j = 0; j < GROUP_N; j++) begin
         if (j < SLOT && grp_alloc[j] && grp_ldst[j] == lreg) out_map = grp_new[j];
      end
   end

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
   parameter int LOG_REGS = 32,
   parameter int PHYS_REGS = 64,
   parameter int GROUP_N = 4,
   parameter int PW = $clog2(PHYS_REGS),
   parameter int CW = $clog2(PHYS_REGS + 1)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [CW-1:0]                    take_n,
   input  logic                             push_en,
   input  logic [PW-1:0]                    push_preg,
   output logic [CW-1:0]                    avail,
   output logic [GROUP_N-1:0][PW-1:0]       peek
);

   localparam int DEPTH   = PHYS_REGS;
   localparam int AW      = $clog2(DEPTH);
   localparam int INIT    = PHYS_REGS - LOG_REGS;
   localparam bit IS_POW2 = ((1 << AW) == DEPTH);

   logic [PW-1:0] slot_q [DEPTH];
   logic [AW-1:0] head_q, tail_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input int unsigned n);
      logic [AW:0] s;
      s = {1'b0, p} + (AW+1)'(n);
      if (int'(s) >= DEPTH) s = s - (AW+1)'(DEPTH);
      return s[AW-1:0];
   endfunction

   for (genvar k = 0; k < GROUP_N; k++) begin : g_peek
      if (IS_POW2) begin : g_wrap
         assign peek[k] = slot_q[head_q + AW'(k)];
      end else begin : g_cmp
         assign peek[k] = slot_q[adv(head_q, k)];
      end
   end

   assign avail = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= (i < INIT) ? PW'(LOG_REGS + i) : '0;
         head_q <= '0;
         tail_q <= AW'(INIT);
         cnt_q  <= CW'(INIT);
      end else begin
         if (push_en) begin
            slot_q[tail_q] <= push_preg;
            tail_q         <= adv(tail_q, 1);
         end
         head_q <= adv(head_q, int'(take_n));
         cnt_q  <= cnt_q - take_n + CW'(push_en);
      end
   end

endmodule

// File: rtl/group_rename.sv
module group_rename #(
   parameter int GROUP_N = 4,
   parameter int LOG_REGS = 32,
   parameter int PHYS_REGS = 64,
   parameter int LW = $clog2(LOG_REGS),
   parameter int PW = $clog2(PHYS_REGS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [GROUP_N-1:0]              in_slot_vld,
   input  logic [GROUP_N-1:0]              in_has_dst,
   input  logic [GROUP_N-1:0][LW-1:0]      in_lsrc_a,
   input  logic [GROUP_N-1:0][LW-1:0]      in_lsrc_b,
   input  logic [GROUP_N-1:0][LW-1:0]      in_ldst,
   input  logic                            rel_valid,
   input  logic [PW-1:0]                   rel_preg,
   output logic                            out_fire,
   output logic                            out_stall,
   output logic [GROUP_N-1:0][PW-1:0]      out_psrc_a,
   output logic [GROUP_N-1:0][PW-1:0]      out_psrc_b,
   output logic [GROUP_N-1:0][PW-1:0]      out_pdst,
   output logic [GROUP_N-1:0][PW-1:0]      out_pold
);

   import rename_pkg::*;

   localparam int CW  = $clog2(PHYS_REGS + 1);
   localparam int GIW = $clog2(GROUP_N);
   localparam int NRD = 3 * GROUP_N;

   if (GROUP_N < 2 || GROUP_N > 32) begin : g_bad_group
      $error("group_rename: GROUP_N must lie in 2..32");
   end
   if (PHYS_REGS <= LOG_REGS + GROUP_N) begin : g_bad_phys
      $error("group_rename: PHYS_REGS must exceed LOG_REGS + GROUP_N");
   end
   if ((1 << LW) != LOG_REGS) begin : g_bad_log
      $error("group_rename: LOG_REGS must be a power of two");
   end

   logic [GROUP_N-1:0]              alloc;
   logic [GROUP_N-1:0][PW-1:0]      new_preg;
   logic [GROUP_N-1:0][GIW-1:0]     pool_ofs;
   logic [NRD-1:0][LW-1:0]          rd_idx;
   logic [NRD-1:0][PW-1:0]          rd_map;
   logic [GROUP_N-1:0][PW-1:0]      map_a, map_b, map_o;
   logic [GROUP_N-1:0][PW-1:0]      fl_peek;
   logic [CW-1:0]                   fl_avail;
   logic [CW-1:0]                   need;
   logic [CW-1:0]                   take;

   for (genvar g = 0; g < GROUP_N; g++) begin : g_slot
      assign alloc[g]      = in_valid & in_slot_vld[g] & in_has_dst[g] & (in_ldst[g] != '0);
      assign pool_ofs[g]   = GIW'(ones_below(32'(alloc), g));
      assign new_preg[g]   = fl_peek[pool_ofs[g]];
      assign rd_idx[3*g]   = in_lsrc_a[g];
      assign rd_idx[3*g+1] = in_lsrc_b[g];
      assign rd_idx[3*g+2] = in_ldst[g];

      rename_dep_check #(.GROUP_N(GROUP_N), .SLOT(g), .LW(LW), .PW(PW)) u_dep_a (
         .lreg(in_lsrc_a[g]), .table_map(rd_map[3*g]), .grp_ldst(in_ldst),
         .grp_alloc(alloc), .grp_new(new_preg), .out_map(map_a[g]));
      rename_dep_check #(.GROUP_N(GROUP_N), .SLOT(g), .LW(LW), .PW(PW)) u_dep_b (
         .lreg(in_lsrc_b[g]), .table_map(rd_map[3*g+1]), .grp_ldst(in_ldst),
         .grp_alloc(alloc), .grp_new(new_preg), .out_map(map_b[g]));
      rename_dep_check #(.GROUP_N(GROUP_N), .SLOT(g), .LW(LW), .PW(PW)) u_dep_o (
         .lreg(in_ldst[g]), .table_map(rd_map[3*g+2]), .grp_ldst(in_ldst),
         .grp_alloc(alloc), .grp_new(new_preg), .out_map(map_o[g]));

      assign out_psrc_a[g] = in_slot_vld[g] ? map_a[g] : '0;
      assign out_psrc_b[g] = in_slot_vld[g] ? map_b[g] : '0;
      assign out_pdst[g]   = alloc[g] ? new_preg[g] : '0;
      assign out_pold[g]   = alloc[g] ? map_o[g] : '0;
   end

   assign need      = CW'($countones(alloc));
   assign out_stall = in_valid && (need > fl_avail);
   assign out_fire  = in_valid && !out_stall;
   assign take      = out_fire ? need : '0;

   rename_map_table #(
      .LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS), .RD_PORTS(NRD),
      .WR_PORTS(GROUP_N), .LW(LW), .PW(PW)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_map(rd_map),
      .wr_en({GROUP_N{out_fire}} & alloc), .wr_idx(in_ldst), .wr_map(new_preg)
   );

   rename_free_list #(
      .LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS), .GROUP_N(GROUP_N), .PW(PW), .CW(CW)
   ) u_pool (
      .clk(clk), .rst_n(rst_n), .take_n(take), .push_en(rel_valid),
      .push_preg(rel_preg), .avail(fl_avail), .peek(fl_peek)
   );

endmodule

// File: rtl/group_rename_chk.sv
module group_rename_chk #(
   parameter int GROUP_N = 4,
   parameter int LW = 5,
   parameter int PW = 6,
   parameter int CW = 7,
   parameter int PHYS_REGS = 64
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_valid,
   input logic [GROUP_N-1:0]            in_slot_vld,
   input logic [GROUP_N-1:0]            in_has_dst,
   input logic [GROUP_N-1:0][LW-1:0]    in_ldst,
   input logic [GROUP_N-1:0][LW-1:0]    in_lsrc_a,
   input logic                          rel_valid,
   input logic                          out_fire,
   input logic                          out_stall,
   input logic [GROUP_N-1:0][PW-1:0]    out_psrc_a,
   input logic [GROUP_N-1:0][PW-1:0]    out_pdst,
   input logic [GROUP_N-1:0][PW-1:0]    out_pold,
   input logic [CW-1:0]                 free_cnt
);

   logic [GROUP_N-1:0] wants;
   for (genvar k = 0; k < GROUP_N; k++) begin : g_w
      assign wants[k] = in_valid & in_slot_vld[k] & in_has_dst[k] & (in_ldst[k] != '0);
   end

   // R8
   stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_stall |-> !out_fire);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_stall && !rel_valid) |=> free_cnt == $past(free_cnt));

   // R8
   fire_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire |-> in_valid);

   // R10
   pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= CW'(PHYS_REGS));

   for (genvar k = 0; k < GROUP_N; k++) begin : g_slot_chk
      // R7
      zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_slot_vld[k] && in_lsrc_a[k] == '0) |-> out_psrc_a[k] == '0);
      // R9
      idle_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wants[k] |-> (out_pdst[k] == '0 && out_pold[k] == '0));
      // R2
      fresh_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_fire && wants[k]) |-> out_pdst[k] != '0);
      for (genvar j = k + 1; j < GROUP_N; j++) begin : g_pair
         // R2
         distinct_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_fire && wants[k] && wants[j]) |-> out_pdst[k] != out_pdst[j]);
      end
   end

endmodule

bind group_rename group_rename_chk #(
   .GROUP_N(GROUP_N), .LW(LW), .PW(PW), .CW($clog2(PHYS_REGS + 1)), .PHYS_REGS(PHYS_REGS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot_vld(in_slot_vld),
   .in_has_dst(in_has_dst), .in_ldst(in_ldst), .in_lsrc_a(in_lsrc_a),
   .rel_valid(rel_valid), .out_fire(out_fire), .out_stall(out_stall),
   .out_psrc_a(out_psrc_a), .out_pdst(out_pdst), .out_pold(out_pold),
   .free_cnt(fl_avail)
);

// File: tb/group_rename_tb.sv
`timescale 1ns/1ps
module group_rename_tb;

   localparam int G  = 4;
   localparam int LW = 5;
   localparam int PW = 6;

   typedef struct packed {
      logic v; logic e;
      logic [4:0] d; logic [4:0] a; logic [4:0] b;
      logic [5:0] xa; logic [5:0] xb; logic [5:0] xd; logic [5:0] xo;
   } slot_t;

   // Four groups of four slots: inputs then expected psrc_a, psrc_b, pdst, pold.
   localparam slot_t VEC [16] = '{
      '{1'b1,1'b1,5'd1,5'd2,5'd3,  6'd2, 6'd3, 6'd32,6'd1},
      '{1'b1,1'b1,5'd4,5'd1,5'd1,  6'd32,6'd32,6'd33,6'd4},
      '{1'b1,1'b1,5'd1,5'd4,5'd5,  6'd33,6'd5, 6'd34,6'd32},
      '{1'b1,1'b1,5'd6,5'd1,5'd0,  6'd34,6'd0, 6'd35,6'd6},
      '{1'b1,1'b1,5'd7,5'd1,5'd4,  6'd34,6'd33,6'd36,6'd7},
      '{1'b1,1'b0,5'd3,5'd6,5'd2,  6'd35,6'd2, 6'd0, 6'd0},
      '{1'b1,1'b1,5'd0,5'd7,5'd1,  6'd36,6'd34,6'd0, 6'd0},
      '{1'b0,1'b1,5'd8,5'd9,5'd9,  6'd0, 6'd0, 6'd0, 6'd0},
      '{1'b1,1'b1,5'd9,5'd9,5'd9,  6'd9, 6'd9, 6'd37,6'd9},
      '{1'b1,1'b1,5'd9,5'd9,5'd9,  6'd37,6'd37,6'd38,6'd37},
      '{1'b1,1'b1,5'd9,5'd9,5'd9,  6'd38,6'd38,6'd39,6'd38},
      '{1'b1,1'b1,5'd9,5'd9,5'd9,  6'd39,6'd39,6'd40,6'd39},
      '{1'b1,1'b0,5'd0,5'd1,5'd4,  6'd34,6'd33,6'd0, 6'd0},
      '{1'b1,1'b0,5'd0,5'd6,5'd7,  6'd35,6'd36,6'd0, 6'd0},
      '{1'b1,1'b0,5'd0,5'd9,5'd2,  6'd40,6'd2, 6'd0, 6'd0},
      '{1'b1,1'b0,5'd0,5'd0,5'd31, 6'd0, 6'd31,6'd0, 6'd0}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic in_valid;
   logic [G-1:0] in_slot_vld, in_has_dst;
   logic [G-1:0][LW-1:0] in_lsrc_a, in_lsrc_b, in_ldst;
   logic rel_valid;
   logic [PW-1:0] rel_preg;
   logic out_fire, out_stall;
   logic [G-1:0][PW-1:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   group_rename u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot_vld(in_slot_vld),
      .in_has_dst(in_has_dst), .in_lsrc_a(in_lsrc_a), .in_lsrc_b(in_lsrc_b),
      .in_ldst(in_ldst), .rel_valid(rel_valid), .rel_preg(rel_preg),
      .out_fire(out_fire), .out_stall(out_stall), .out_psrc_a(out_psrc_a),
      .out_psrc_b(out_psrc_b), .out_pdst(out_pdst), .out_pold(out_pold)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_group();
      in_valid    = 1'b0;
      in_slot_vld = '0;
      in_has_dst  = '0;
      in_lsrc_a   = '0;
      in_lsrc_b   = '0;
      in_ldst     = '0;
   endtask

   task automatic put_slot(input int k, input logic v, input logic e,
                           input int d, input int a, input int b);
      in_valid       = 1'b1;
      in_slot_vld[k] = v;
      in_has_dst[k]  = e;
      in_ldst[k]     = LW'(d);
      in_lsrc_a[k]   = LW'(a);
      in_lsrc_b[k]   = LW'(b);
   endtask

   function automatic string group_tag(input int g);
      case (g)
         0:       return "R1/R2/R3/R4/R6";
         1:       return "R7/R9";
         2:       return "R2/R6";
         default: return "R3/R5";
      endcase
   endfunction

   initial begin
      #(5 * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      rel_valid = 1'b0;
      rel_preg = '0;
      clear_group();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1.5;
      check("R1 idle fire", int'(out_fire), 0);
      check("R1 idle stall", int'(out_stall), 0);

      // Table-driven groups
      for (int g = 0; g < 4; g++) begin
         @(negedge clk);
         clear_group();
         for (int k = 0; k < G; k++) begin
            slot_t s;
            s = VEC[g*G + k];
            put_slot(k, s.v, s.e, int'(s.d), int'(s.a), int'(s.b));
         end
         #1.5;
         check({group_tag(g), " fire"}, int'(out_fire), 1);
         for (int k = 0; k < G; k++) begin
            slot_t s;
            s = VEC[g*G + k];
            check($sformatf("%s slot%0d psrc_a", group_tag(g), k), int'(out_psrc_a[k]), int'(s.xa));
            check($sformatf("%s slot%0d psrc_b", group_tag(g), k), int'(out_psrc_b[k]), int'(s.xb));
            check($sformatf("%s slot%0d pdst", group_tag(g), k), int'(out_pdst[k]), int'(s.xd));
            check($sformatf("%s slot%0d pold", group_tag(g), k), int'(out_pold[k]), int'(s.xo));
         end
      end

      // Drain the pool down to three entries (61, 62, 63 remain)
      for (int n = 0; n < 5; n++) begin
         @(negedge clk);
         clear_group();
         for (int k = 0; k < G; k++) put_slot(k, 1'b1, 1'b1, 10, 0, 0);
         #1.5;
         check("R8 drain no stall", int'(out_stall), 0);
         check("R2 drain order", int'(out_pdst[0]), 41 + 4*n);
         check("R5 drain last slot", int'(out_pdst[3]), 44 + 4*n);
      end

      // R8: four needed, three held
      @(negedge clk);
      clear_group();
      for (int k = 0; k < G; k++) put_slot(k, 1'b1, 1'b1, k + 1, 0, 0);
      #1.5;
      check("R8 short stall", int'(out_stall), 1);
      check("R8 short fire", int'(out_fire), 0);

      // R8: state unchanged after the stall
      @(negedge clk);
      clear_group();
      put_slot(0, 1'b1, 1'b1, 11, 1, 0);
      put_slot(1, 1'b1, 1'b1, 12, 2, 0);
      put_slot(2, 1'b1, 1'b1, 13, 10, 0);
      #1.5;
      check("R8 after stall", int'(out_stall), 0);
      check("R8 r1 kept", int'(out_psrc_a[0]), 34);
      check("R8 r2 kept", int'(out_psrc_a[1]), 2);
      check("R5 r10 last writer", int'(out_psrc_a[2]), 60);
      check("R8 pool kept s0", int'(out_pdst[0]), 61);
      check("R8 pool kept s1", int'(out_pdst[1]), 62);
      check("R8 pool kept s2", int'(out_pdst[2]), 63);
      check("R6 pold s2", int'(out_pold[2]), 13);

      // R10: pool empty, release in the same cycle does not help
      @(negedge clk);
      clear_group();
      put_slot(0, 1'b1, 1'b1, 14, 11, 0);
      rel_valid = 1'b1;
      rel_preg  = 6'd50;
      #1.5;
      check("R10 same-cycle release", int'(out_stall), 1);

      @(negedge clk);
      rel_preg = 6'd20;
      #1.5;
      check("R10 released usable", int'(out_stall), 0);
      check("R10 released pdst", int'(out_pdst[0]), 50);
      check("R10 psrc r11", int'(out_psrc_a[0]), 61);
      check("R10 pold r14", int'(out_pold[0]), 14);

      @(negedge clk);
      rel_valid = 1'b0;
      clear_group();
      put_slot(0, 1'b1, 1'b1, 15, 14, 0);
      #1.5;
      check("R10 second release", int'(out_pdst[0]), 20);
      check("R10 r14 mapped", int'(out_psrc_a[0]), 50);

      // R7: empty pool, group needing nothing is accepted
      @(negedge clk);
      clear_group();
      put_slot(0, 1'b1, 1'b1, 0, 0, 0);
      put_slot(1, 1'b1, 1'b0, 5, 15, 0);
      #1.5;
      check("R7 zero dst no stall", int'(out_stall), 0);
      check("R7 zero dst fire", int'(out_fire), 1);
      check("R7 zero dst pdst", int'(out_pdst[0]), 0);
      check("R7 zero dst pold", int'(out_pold[0]), 0);
      check("R9 no-dst pdst", int'(out_pdst[1]), 0);
      check("R9 r15 mapped", int'(out_psrc_a[1]), 20);

      @(negedge clk);
      clear_group();
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule